// File: doc/BRIEF.md
# Multi-Mode Reload Timer

A single channel of programmable counting built around one counter and one reload register. A small write-only register bus sets the operating mode, the count value and a control word. The mode is one of four: a periodic timer that can be held by an external gate, an event counter that follows the edges of an external pin, a retriggerable one-shot, and a basic pulse-width generator. The counter value is always visible on an output. Each mode reports its reload or expiry events as a one-cycle interrupt request and as an inversion of a toggle output.

The counter advances on one of four prescaled clock enables, chosen by the mode register. The exception is event-counter mode, where each rising edge of the external pin advances it. A write to the count address while the channel is stopped presets both the counter and the reload register. A write while the channel is running changes only the reload value, which the counter picks up at its next reload.

Top module: `mrt_timer`

## Requirements
- R1: After reset `count_o` is 0, `irq_o` is 0 and `tout_o` is 0, and the channel is stopped in timer mode.
- R2: A write to address 1 while the start flag (bit 0 of the control word at address 2) is 0 loads the written value into both the counter and the reload register. While the start flag is 0 the counter holds its value.
- R3: In timer mode (mode word at address 0, bits 1:0 = 00) the counter decrements once per cycle in which the prescaled enable chosen by mode bits 7:6 is high. An enable cycle that finds the counter at 0 reloads it instead and raises `irq_o` for one cycle, so consecutive requests are (reload+1)·2^k cycles apart when enable k is high every 2^k cycles.
- R4: A write to address 1 while running changes only the reload register. The count in progress continues, and the new value appears in the counter at the next reload.
- R5: In timer mode with mode bit 4 = 1, the counter advances only while `ext_in` equals mode bit 3. With bit 4 = 0, bit 3 and `ext_in` have no effect.
- R6: In event-counter mode (bits 1:0 = 01) with control bit 1 = 0, each rising edge of `ext_in` decrements the counter once, however long the pin stays high. An edge that finds the counter at 0 reloads it and raises `irq_o`.
- R7: In event-counter mode with control bit 1 = 1 the counter increments, and an edge that finds it at 0xFFFF reloads it and raises `irq_o`. In every other mode control bit 1 has no effect and the counter counts down.
- R8: `tout_o` inverts on every reload event, and each `irq_o` pulse coincides with an inversion of `tout_o`.
- R9: In one-shot mode (bits 1:0 = 10), a rising edge of `trig_in` while running and idle loads the reload value and inverts `tout_o`. The counter then decrements on the selected enable. The enable cycle that finds it at 0 ends the shot: `irq_o` pulses, `tout_o` inverts back, and the counter holds 0 until the next trigger.
- R10: In pulse-width mode (bits 1:0 = 11) the counter reloads as in timer mode but ignores the gate. `tout_o` inverts on each reload, and `irq_o` pulses only on the reloads where `tout_o` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 count/reload, 2 control (bit 0 start, bit 1 up) |
| wr_data | input | W (16) | Write data |
| clk_en | input | NCLK (4) | Prescaled clock enables |
| ext_in | input | 1 | External gate or event pin |
| trig_in | input | 1 | One-shot trigger |
| count_o | output | W (16) | Current counter value |
| irq_o | output | 1 | One-cycle interrupt request |
| tout_o | output | 1 | Toggle output |

## Verification
The bench builds the channel with its defaults: a 16-bit counter and four clock enables. It drives enable k high once every 2^k cycles, so every clock selection gives a distinct, predictable request interval. With a 16-bit counter, the 0xFFFF-to-reload wrap of the up-counting event mode is reached in two edges, by presetting the counter just below the limit.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    MD_TIMER   = 2'b00,
    MD_EVENT   = 2'b01,
    MD_ONESHOT = 2'b10,
    MD_PWM     = 2'b11
  } mrt_mode_e;

  typedef struct packed {
    logic [1:0] csel;
    logic       gate_en;
    logic       gate_pol;
    mrt_mode_e  md;
  } mrt_cfg_t;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/mrt_tick_sel.sv
module mrt_tick_sel
  import mrt_pkg::*;
#(
  parameter int NCLK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLK-1:0] clk_en,
  input  logic [1:0]      csel,
  input  logic            gate_en,
  input  logic            gate_pol,
  input  mrt_mode_e       md,
  input  logic            run,
  input  logic            ext_in,
  input  logic            trig_in,
  output logic            tick,
  output logic            trig_rise
);
  logic ext_q, trig_q;
  logic pre_en, gate_ok, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      ext_q  <= ext_in;
      trig_q <= trig_in;
    end
  end

  assign pre_en    = clk_en[csel];
  assign gate_ok   = !gate_en || (ext_in == gate_pol);
  assign ext_rise  = ext_in && !ext_q;
  assign trig_rise = trig_in && !trig_q;

  always_comb begin
    unique case (md)
      MD_EVENT: tick = run && ext_rise;
      MD_TIMER: tick = run && pre_en && gate_ok;
      default:  tick = run && pre_en;
    endcase
  end
endmodule

// File: rtl/mrt_counter.sv
module mrt_counter
  import mrt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mrt_mode_e    md,
  input  logic         run,
  input  logic         up,
  input  logic         tick,
  input  logic         trig_rise,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         wrap_ev,
  output logic         os_start,
  output logic         os_end
);
  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic dir_up);
    return dir_up ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic logic at_limit(input logic [W-1:0] v, input logic dir_up);
    return dir_up ? (v == ALL_ONE) : (v == '0);
  endfunction

  logic [W-1:0] reload_q;
  logic         active_q;
  logic         up_eff, limit, is_os;

  assign up_eff   = (md == MD_EVENT) && up;
  assign limit    = at_limit(count, up_eff);
  assign is_os    = (md == MD_ONESHOT);
  assign wrap_ev  = tick && limit && !is_os;
  assign os_start = run && is_os && !active_q && trig_rise;
  assign os_end   = is_os && active_q && tick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      active_q <= 1'b0;
    end else begin
      if (cnt_wr) begin
        reload_q <= wr_data;
        if (!run) count <= wr_data;
      end
      if (!run) begin
        active_q <= 1'b0;
      end else if (is_os) begin
        if (os_start) begin
          count    <= reload_q;
          active_q <= 1'b1;
        end else if (active_q && tick) begin
          if (count == '0) active_q <= 1'b0;
          else             count    <= step(count, 1'b0);
        end
      end else if (tick) begin
        count <= limit ? reload_q : step(count, up_eff);
      end
    end
  end
endmodule

// File: rtl/mrt_timer.sv
module mrt_timer
  import mrt_pkg::*;
#(
  parameter int W    = 16,
  parameter int NCLK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [NCLK-1:0] clk_en,
  input  logic            ext_in,
  input  logic            trig_in,
  output logic [W-1:0]    count_o,
  output logic            irq_o,
  output logic            tout_o
);
  mrt_cfg_t cfg_q;
  logic     run_q, up_q;
  logic     cnt_wr, tick, trig_rise;
  logic     wrap_ev, os_start, os_end;
  logic     flip, irq_set;

  assign cnt_wr = wr_en && (wr_addr == ADDR_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{csel: 2'b00, gate_en: 1'b0, gate_pol: 1'b0, md: MD_TIMER};
      run_q <= 1'b0;
      up_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MODE) begin
        cfg_q.csel     <= wr_data[7:6];
        cfg_q.gate_en  <= wr_data[4];
        cfg_q.gate_pol <= wr_data[3];
        cfg_q.md       <= mrt_mode_e'(wr_data[1:0]);
      end
      if (wr_addr == ADDR_CTRL) begin
        run_q <= wr_data[0];
        up_q  <= wr_data[1];
      end
    end
  end

  mrt_tick_sel #(.NCLK(NCLK)) tick_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .csel(cfg_q.csel),
    .gate_en(cfg_q.gate_en), .gate_pol(cfg_q.gate_pol), .md(cfg_q.md),
    .run(run_q), .ext_in(ext_in), .trig_in(trig_in),
    .tick(tick), .trig_rise(trig_rise)
  );

  mrt_counter #(.W(W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .md(cfg_q.md), .run(run_q), .up(up_q),
    .tick(tick), .trig_rise(trig_rise), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .count(count_o), .wrap_ev(wrap_ev), .os_start(os_start), .os_end(os_end)
  );

  assign flip    = wrap_ev || os_start || os_end;
  assign irq_set = (cfg_q.md == MD_PWM) ? (wrap_ev && tout_o) : (wrap_ev || os_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      tout_o <= tout_o ^ flip;
      irq_o  <= irq_set;
    end
  end
endmodule

// File: rtl/mrt_timer_chk.sv
module mrt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic         ext_in,
  input logic [W-1:0] count_o,
  input logic         irq_o,
  input logic         tout_o,
  input logic         run_q,
  input logic [1:0]   md,
  input logic         gate_en,
  input logic         gate_pol,
  input logic         tick
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == 2'd1);

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q && !cnt_wr) |-> $stable(count_o));

  p_timer_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && md == 2'b00 && count_o != '0) |-> count_o == W'($past(count_o) - 1'b1));

  p_no_irq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q) |-> !irq_o);

  p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q && md == 2'b00 && gate_en && ext_in != gate_pol) |-> $stable(count_o));

  p_irq_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> tout_o != $past(tout_o));

  p_pwm_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(md == 2'b11)) |-> !tout_o);
endmodule

bind mrt_timer mrt_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ext_in(ext_in),
  .count_o(count_o), .irq_o(irq_o), .tout_o(tout_o), .run_q(run_q),
  .md(cfg_q.md), .gate_en(cfg_q.gate_en), .gate_pol(cfg_q.gate_pol), .tick(tick)
);

// File: tb/mrt_timer_tb_top.sv
module mrt_timer_tb_top;
  localparam int W = 16;
  localparam int NCLK = 4;
  localparam int NV = 7;
  // each entry: {clock select[17:16], reload[15:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'd3}, {2'd0, 16'd0}, {2'd1, 16'd2}, {2'd2, 16'd1},
    {2'd3, 16'd4}, {2'd0, 16'd9}, {2'd1, 16'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = 2'd0;
  logic [W-1:0]    wr_data = '0;
  logic [NCLK-1:0] clk_en = '0;
  logic            ext_in = 1'b0;
  logic            trig_in = 1'b0;
  logic [W-1:0]    count_o;
  logic            irq_o, tout_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int unsigned div = 0;

  mrt_timer #(.W(W), .NCLK(NCLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_en(clk_en), .ext_in(ext_in), .trig_in(trig_in),
    .count_o(count_o), .irq_o(irq_o), .tout_o(tout_o)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      for (int k = 0; k < NCLK; k++) clk_en[k] = ((div % (32'd1 << k)) == 0);
      div++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_o && n < 2000);
  endtask

  bit ev_irq;
  task automatic pulse(input int hi);
    ext_in = 1'b1;
    @(negedge clk);
    ev_irq = irq_o;
    repeat (hi - 1) @(negedge clk);
    ext_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, v;
    bit t0, t1;
    int irqs, falls;
    bit prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(count_o == 0 && !irq_o && !tout_o, "R1 reset", int'(count_o), 0);

    // R3 interval table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 16'h0);
      wr(2'd0, W'({VEC[i][17:16], 6'b0}));
      wr(2'd1, VEC[i][15:0]);
      wr(2'd2, 16'h1);
      wait_irq(n);
      wait_irq(n);
      check(n == ((int'(VEC[i][15:0]) + 1) << VEC[i][17:16]), "R3 interval", n,
            (int'(VEC[i][15:0]) + 1) << VEC[i][17:16]);
    end

    // R2 preset and hold while stopped
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h1234);
    check(count_o == 16'h1234, "R2 preset", int'(count_o), 'h1234);
    repeat (6) @(negedge clk);
    check(count_o == 16'h1234, "R2 hold", int'(count_o), 'h1234);

    // R4 write while running changes reload only
    wr(2'd1, 16'd100);
    wr(2'd2, 16'h1);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd5);
    check(count_o > 16'd90, "R4 count kept", int'(count_o), 94);
    wait_irq(n);
    check(count_o == 16'd5, "R4 new reload", int'(count_o), 5);
    // R8 toggle alternates between reloads
    t0 = tout_o;
    wait_irq(n);
    t1 = tout_o;
    check(t1 != t0, "R8 toggle", int'(t1), int'(!t0));

    // R5 gate active-high
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h18);
    wr(2'd1, 16'd50);
    ext_in = 1'b0;
    wr(2'd2, 16'h1);
    repeat (5) @(negedge clk);
    check(count_o == 16'd50, "R5 gate closed", int'(count_o), 50);
    ext_in = 1'b1;
    repeat (5) @(negedge clk);
    check(count_o == 16'd45, "R5 gate open", int'(count_o), 45);
    ext_in = 1'b0;
    // R5 polarity bit ignored without gate enable
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h08);
    wr(2'd1, 16'd50);
    wr(2'd2, 16'h1);
    repeat (5) @(negedge clk);
    check(count_o == 16'd45, "R5 no gate", int'(count_o), 45);

    // R6 event counting down
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h01);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h1);
    pulse(4);
    check(count_o == 16'd1 && !ev_irq, "R6 one edge", int'(count_o), 1);
    pulse(1);
    check(count_o == 16'd0, "R6 second edge", int'(count_o), 0);
    pulse(1);
    check(count_o == 16'd2 && ev_irq, "R6 reload irq", int'(count_o) + 1000 * int'(ev_irq), 1002);

    // R7 event counting up across 0xFFFF
    wr(2'd2, 16'h0);
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h3);
    wr(2'd1, 16'd7);
    pulse(1);
    check(count_o == 16'hFFFF && !ev_irq, "R7 up step", int'(count_o), 'hFFFF);
    pulse(1);
    check(count_o == 16'd7 && ev_irq, "R7 up wrap", int'(count_o), 7);
    // R7 up flag ignored in timer mode
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd10);
    wr(2'd2, 16'h3);
    repeat (3) @(negedge clk);
    check(count_o == 16'd7, "R7 timer down", int'(count_o), 7);

    // R9 one-shot
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h02);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'h1);
    t0 = tout_o;
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    check(count_o == 16'd4 && tout_o != t0, "R9 start", int'(count_o), 4);
    repeat (4) @(negedge clk);
    check(count_o == 16'd0 && !irq_o && tout_o != t0, "R9 running", int'(irq_o), 0);
    @(negedge clk);
    check(irq_o && tout_o == t0, "R9 end", int'(irq_o), 1);
    repeat (5) @(negedge clk);
    check(count_o == 16'd0 && tout_o == t0, "R9 idle", int'(count_o), 0);

    // R10 pulse-width, gate enabled but ignored
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h1B);
    wr(2'd1, 16'd1);
    ext_in = 1'b0;
    wr(2'd2, 16'h1);
    irqs = 0; falls = 0; prev = tout_o;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (irq_o) irqs++;
      if (prev && !tout_o) falls++;
      prev = tout_o;
    end
    check(irqs == falls, "R10 irq on fall", irqs, falls);
    check(irqs >= 9 && irqs <= 11, "R10 rate", irqs, 10);

    v = 0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails + v);
    $finish;
  end
endmodule